// File: doc/BRIEF.md
# One-Time-Programmable Word Memory

A clocked, synthesizable model of a 16-bit-wide programmable read-only store. Every bit starts as one after an erase. A programming pulse can only clear bits, because the new word is the bitwise AND of the stored word and the input data. Reads are gated by two active-low enables, one that selects the chip and one that enables the output. When either is inactive, the output is treated as floating, which is shown as a low valid flag and an all-zero data bus.

Two mode inputs stand in for the analog conditions. `hv_prog_i` means the programming supply is present, and `id_mode_i` means the identification condition is present. With the programming supply present, the block can program a word, inhibit programming when the chip is not selected, or verify the stored word. In identification mode, address bit 0 chooses between a manufacturer word and a device word. Both words are parameters with odd parity. A separate `wipe_i` input returns the whole array to all ones in one cycle. The array keeps its contents across `rst_n`.

Top module: `otp_word_mem`

## Requirements
- R1: One cycle after `wipe_i` is high at a clock edge, every word reads 16'hFFFF.
- R2: A programming cycle writes (stored AND `wdata_i`) into the addressed word, so a bit that is zero never returns to one.
- R3: `rvalid_o` is high only when `ce_n_i` and `oe_n_i` were both low in the previous cycle; whenever `rvalid_o` is low, `rdata_o` is 16'h0000.
- R4: A read (`hv_prog_i`=0, `id_mode_i`=0, `ce_n_i`=0, `oe_n_i`=0) presents the stored word with `rvalid_o`=1 exactly one clock edge later.
- R5: In identification mode (`hv_prog_i`=0, `id_mode_i`=1, both enables low), `addr_i[0]`=0 returns `MFR_CODE` and `addr_i[0]`=1 returns `DEV_CODE`; the other address bits are ignored.
- R6: Both identification words have odd parity over their 16 bits, with bit 15 serving as the parity bit; this is checked when the design is elaborated.
- R7: With `hv_prog_i`=1 and `ce_n_i`=1, no word changes even while `pgm_n_i` is low (program inhibit).
- R8: With `hv_prog_i`=1, `ce_n_i`=0, `oe_n_i`=0 and `pgm_n_i`=1, the stored word is returned one cycle later with `rvalid_o`=1 (program verify).
- R9: A word is written only when `hv_prog_i`=1, `ce_n_i`=0, `pgm_n_i`=0 and `oe_n_i`=1. A low `pgm_n_i` without the programming supply, or with `oe_n_i` low, writes nothing.
- R10: When `wipe_i` and a programming cycle occur at the same edge, the wipe wins and the addressed word ends as all ones.
- R11: A low `rst_n` clears `rvalid_o` and `rdata_o` and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| wipe_i | input | 1 | Sets every array bit to one |
| hv_prog_i | input | 1 | Programming supply present |
| id_mode_i | input | 1 | Identification condition present |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| pgm_n_i | input | 1 | Program pulse, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Data to program |
| rdata_o | output | 16 | Read, verify or identification word |
| rvalid_o | output | 1 | Output is driven |

## Verification
The array checks assume the contents are defined, so they stay silent until the first wipe has been applied. The stimulus wipes the array right after reset and does not check any read before that point. The output checks assume the control inputs are stable around each rising edge. The stimulus therefore changes every input on the falling edge and samples one time unit after the rising edge. Simultaneous wipe and program appear only in the one scenario built for R10.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_IDENT,
        OP_PROG,
        OP_VERIFY,
        OP_INHIBIT
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } port_state_t;

    function automatic logic odd_parity(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hv_prog_i,
    input  logic id_mode_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic pgm_n_i,
    output op_e  op_o,
    output logic prog_we_o
);

    always_comb begin
        op_o = OP_IDLE;
        if (hv_prog_i) begin
            if (ce_n_i) begin
                op_o = OP_INHIBIT;
            end else if (!pgm_n_i && oe_n_i) begin
                op_o = OP_PROG;
            end else if (pgm_n_i && !oe_n_i) begin
                op_o = OP_VERIFY;
            end
        end else if (!ce_n_i && !oe_n_i) begin
            op_o = id_mode_i ? OP_IDENT : OP_READ;
        end
    end

    assign prog_we_o = (op_o == OP_PROG);

    // R7: an unselected device never programs
    p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_prog_i && ce_n_i) |-> !prog_we_o);

    // R9: no write without the programming supply or with the output enabled
    p_write_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_prog_i || !oe_n_i) |-> !prog_we_o);

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
    import otp_pkg::*;
#(
    parameter logic [WORD_W-1:0] MFR_CODE = 16'h0A51,
    parameter logic [WORD_W-1:0] DEV_CODE = 16'h8E07
) (
    input  logic              sel_i,
    output logic [WORD_W-1:0] code_o
);

    assign code_o = sel_i ? DEV_CODE : MFR_CODE;

    // R6: identification words must carry odd parity
    initial begin
        p_mfr_odd_r6: assert (odd_parity(MFR_CODE))
            else $error("manufacturer word has even parity");
        p_dev_odd_r6: assert (odd_parity(DEV_CODE))
            else $error("device word has even parity");
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_i,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rd_word_o
);

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [WORD_W-1:0] word_d;
        logic [WORD_W-1:0] word_q;

        always_comb begin
            word_d = word_q;
            if (wipe_i) begin
                word_d = '1;
            end else if (we_i && (addr_i == AW'(g))) begin
                word_d = word_q & wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            word_q <= word_d;
        end

        assign words[g] = word_q;
    end

    assign rd_word_o = words[addr_i];

    initial begin
        p_depth_pow2: assert (DEPTH == (1 << AW))
            else $error("DEPTH must be a power of two");
    end

    // contents are undefined until the first wipe
    logic known_q;
    always_ff @(posedge clk) begin
        if (wipe_i) begin
            known_q <= 1'b1;
        end
    end

    // R1: a wipe leaves every word at all ones
    p_wipe_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> (rd_word_o == '1));

    // R2: programming never sets a bit
    p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (known_q === 1'b1 && we_i && !wipe_i)
        |=> ((words[$past(addr_i)] & ~$past(rd_word_o)) == '0));

    // R7: without a write or wipe the addressed word holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (known_q === 1'b1 && !we_i && !wipe_i)
        |=> (words[$past(addr_i)] == $past(rd_word_o)));

endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
    import otp_pkg::*;
#(
    parameter int                DEPTH    = 256,
    parameter logic [WORD_W-1:0] MFR_CODE = 16'h0A51,
    parameter logic [WORD_W-1:0] DEV_CODE = 16'h8E07,
    localparam int               AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_i,
    input  logic              hv_prog_i,
    input  logic              id_mode_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              pgm_n_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);

    op_e               op;
    logic              prog_we;
    logic [WORD_W-1:0] cell_word;
    logic [WORD_W-1:0] id_word;
    port_state_t       st_d;
    port_state_t       st_q;

    otp_mode_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .hv_prog_i (hv_prog_i),
        .id_mode_i (id_mode_i),
        .ce_n_i    (ce_n_i),
        .oe_n_i    (oe_n_i),
        .pgm_n_i   (pgm_n_i),
        .op_o      (op),
        .prog_we_o (prog_we)
    );

    otp_cell_array #(.DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_i    (wipe_i),
        .we_i      (prog_we),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rd_word_o (cell_word)
    );

    otp_id_rom #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
        .sel_i  (addr_i[0]),
        .code_o (id_word)
    );

    always_comb begin
        st_d = '0;
        unique case (op)
            OP_READ, OP_VERIFY: begin
                st_d.valid = 1'b1;
                st_d.data  = cell_word;
            end
            OP_IDENT: begin
                st_d.valid = 1'b1;
                st_d.data  = id_word;
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.data;
    assign rvalid_o = st_q.valid;

    // R3: driven output requires both enables one cycle earlier
    p_valid_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(!ce_n_i && !oe_n_i));

    // R3: a floating bus reads as zero
    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

    // R4: plain read returns the addressed word one edge later
    p_read_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_prog_i && !id_mode_i && !ce_n_i && !oe_n_i)
        |=> (rvalid_o && rdata_o == $past(cell_word)));

    // R5: identification word follows address bit 0
    p_ident_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_prog_i && id_mode_i && !ce_n_i && !oe_n_i)
        |=> (rvalid_o && rdata_o == ($past(addr_i[0]) ? DEV_CODE : MFR_CODE)));

    // R8: verify drives the output under programming supply
    p_verify_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_prog_i && !ce_n_i && !oe_n_i && pgm_n_i) |=> rvalid_o);

endmodule

// File: tb/otp_word_mem_tb.sv
module otp_word_mem_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 256;
    localparam int          AW         = $clog2(DEPTH);
    localparam logic [15:0] MFR        = 16'h0A51;
    localparam logic [15:0] DEV        = 16'h8E07;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wipe_i;
    logic          hv_prog_i;
    logic          id_mode_i;
    logic          ce_n_i;
    logic          oe_n_i;
    logic          pgm_n_i;
    logic [AW-1:0] addr_i;
    logic [15:0]   wdata_i;
    logic [15:0]   rdata_o;
    logic          rvalid_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    otp_word_mem #(.DEPTH(DEPTH), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_i    (wipe_i),
        .hv_prog_i (hv_prog_i),
        .id_mode_i (id_mode_i),
        .ce_n_i    (ce_n_i),
        .oe_n_i    (oe_n_i),
        .pgm_n_i   (pgm_n_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     req, act[16], act[15:0], exp[16], exp[15:0]);
        end
    endtask

    // drive on the falling edge, sample one unit after the rising edge
    task automatic step(input logic ce_n, input logic oe_n, input logic pgm_n,
                        input logic hv, input logic idm, input logic wipe,
                        input logic [AW-1:0] a, input logic [15:0] wd);
        @(negedge clk);
        ce_n_i = ce_n; oe_n_i = oe_n; pgm_n_i = pgm_n;
        hv_prog_i = hv; id_mode_i = idm; wipe_i = wipe;
        addr_i = a; wdata_i = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1, 1, 1, 0, 0, 0, '0, '0);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        step(0, 0, 1, 0, 0, 0, a, '0);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [15:0] wd);
        step(0, 1, 0, 1, 0, 0, a, wd);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        idle();
        idle();
        chk("R11 reset clears output", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        rst_n = 1'b1;
    endtask

    task automatic t_wipe();
        step(1, 1, 1, 0, 0, 1, '0, '0);
        rd(8'd0);   chk("R1 word 0 after wipe",   {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        rd(8'd127); chk("R1 word 127 after wipe", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        rd(8'd255); chk("R1 word 255 after wipe", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        idle();
    endtask

    task automatic t_latency();
        prog(8'd20, 16'h5AA5);
        @(negedge clk);
        ce_n_i = 0; oe_n_i = 0; pgm_n_i = 1; hv_prog_i = 0; id_mode_i = 0;
        wipe_i = 0; addr_i = 8'd20; wdata_i = '0;
        #1;
        chk("R4 not valid before edge", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        @(posedge clk);
        #1;
        chk("R4 valid one edge later", {rvalid_o, rdata_o}, {1'b1, 16'h5AA5});
        idle();
        chk("R3 drops after enables release", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
    endtask

    task automatic t_program();
        prog(8'd5, 16'hF0F0);
        chk("R9 no output while programming", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        rd(8'd5);
        chk("R2 first program", {rvalid_o, rdata_o}, {1'b1, 16'hF0F0});
        prog(8'd5, 16'hFF0F);
        rd(8'd5);
        chk("R2 ones not restored", {rvalid_o, rdata_o}, {1'b1, 16'hF000});
        step(0, 1, 0, 0, 0, 0, 8'd6, 16'h0000);
        rd(8'd6);
        chk("R9 pulse without supply", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        step(0, 0, 0, 1, 0, 0, 8'd6, 16'h0000);
        chk("R9 pulse with output enabled gives no output", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        rd(8'd6);
        chk("R9 pulse with output enabled", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        idle();
    endtask

    task automatic t_enables();
        step(0, 1, 1, 0, 0, 0, 8'd5, '0);
        chk("R3 output enable high", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        step(1, 0, 1, 0, 0, 0, 8'd5, '0);
        chk("R3 chip select high", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        step(0, 0, 1, 0, 1, 0, 8'd1, '0);
        step(0, 1, 1, 0, 1, 0, 8'd1, '0);
        chk("R3 ident with output disabled", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        idle();
    endtask

    task automatic t_ident();
        step(0, 0, 1, 0, 1, 0, 8'h00, '0);
        chk("R5 manufacturer at 0", {rvalid_o, rdata_o}, {1'b1, MFR});
        chk("R6 manufacturer odd parity", {16'h0, ^rdata_o}, {16'h0, 1'b1});
        step(0, 0, 1, 0, 1, 0, 8'h01, '0);
        chk("R5 device at 1", {rvalid_o, rdata_o}, {1'b1, DEV});
        chk("R6 device odd parity", {16'h0, ^rdata_o}, {16'h0, 1'b1});
        step(0, 0, 1, 0, 1, 0, 8'h80, '0);
        chk("R5 upper bits ignored even", {rvalid_o, rdata_o}, {1'b1, MFR});
        step(0, 0, 1, 0, 1, 0, 8'hFF, '0);
        chk("R5 upper bits ignored odd", {rvalid_o, rdata_o}, {1'b1, DEV});
        idle();
    endtask

    task automatic t_inhibit();
        step(1, 1, 0, 1, 0, 0, 8'd9, 16'h0000);
        chk("R7 no output while inhibited", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        step(1, 0, 0, 1, 0, 0, 8'd9, 16'h0000);
        rd(8'd9);
        chk("R7 word unchanged", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        idle();
    endtask

    task automatic t_verify();
        step(0, 0, 1, 1, 0, 0, 8'd5, 16'h0000);
        chk("R8 verify returns stored word", {rvalid_o, rdata_o}, {1'b1, 16'hF000});
        step(0, 0, 1, 1, 0, 0, 8'd9, 16'h1234);
        chk("R8 verify other word", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        idle();
    endtask

    task automatic t_wipe_priority();
        step(0, 1, 0, 1, 0, 1, 8'd7, 16'h0000);
        rd(8'd7);
        chk("R10 wipe beats program", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        rd(8'd5);
        chk("R10 other words wiped", {rvalid_o, rdata_o}, {1'b1, 16'hFFFF});
        idle();
    endtask

    task automatic t_reset_keeps();
        prog(8'd3, 16'h1234);
        rd(8'd3);
        rst_n = 1'b0;
        rd(8'd3);
        chk("R11 reset clears output during read", {rvalid_o, rdata_o}, {1'b0, 16'h0000});
        rst_n = 1'b1;
        rd(8'd3);
        chk("R11 contents kept across reset", {rvalid_o, rdata_o}, {1'b1, 16'h1234});
        idle();
    endtask

    initial begin
        rst_n = 1'b0; wipe_i = 0; hv_prog_i = 0; id_mode_i = 0;
        ce_n_i = 1; oe_n_i = 1; pgm_n_i = 1; addr_i = '0; wdata_i = '0;
        t_reset_state();
        t_wipe();
        t_latency();
        t_program();
        t_enables();
        t_ident();
        t_inhibit();
        t_verify();
        t_wipe_priority();
        t_reset_keeps();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule